// File: doc/BRIEF.md
# Register-Driven SPI Flash Transaction Engine

This block issues one serial-flash transaction at a time under software control. Software fills a small register bank with an opcode, an optional address of up to four bytes, a dummy byte count, and up to sixteen bytes to send or to receive. It picks a lane width (one, two or four data lines) for each phase and chooses which chip select to drive. Writing the start bit launches the transfer. The engine clocks out the phases in a fixed sequence and drops received bytes into the read-data words. The start bit reads back as a busy flag until the transfer ends.

Software builds long flash commands (page programs, long reads) from several short transactions. It clears the release bit so that the chosen chip select stays low between them, then sets it to end the command. A sticky ready flag, with an optional interrupt, marks each completion.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, no data line is driven, the interrupt is low, and the control word (offset 0x0C) reads 0x0001_0000: release bit 16 set, busy bit 0, ready bit 24 and interrupt-enable bit 25 clear.
- R2: A transaction runs its phases in this order: opcode, address, dummy, write data, read data. A phase with length zero is skipped, and a transaction with every length zero produces no clock edge. The clock idles low, each bit is presented while the clock is low and sampled on its rising edge, and every byte goes most significant bit first.
- R3: Each lane-width field in the configuration word (offset 0x08) holds log2 of the line count: 0 = one line, 1 = two, 2 = four. One-line output goes on io[0] and one-line input comes from io[1]. Two-line transfers use io[1:0], with the higher bit on io[1]. Four-line transfers use io[3:0], with the higher bit on io[3]. The field positions are: opcode 1:0, address 3:2, write 5:4, dummy 7:6, read 9:8.
- R4: Configuration bit 10 enables the opcode byte, which is taken from bits 7:0 at offset 0x10. Bits 13:11 give the address length N (0 to 4). The address bytes are the low N bytes of the word at 0x14, sent most significant first.
- R5: Bits 20:16 give the write byte count (0 to 16). Write byte k comes from the word at 0x20 + 4*(k/4), bits 8*(k%4)+7 : 8*(k%4).
- R6: Bits 28:24 give the read byte count (0 to 16). Received byte k is stored at the same position in the words at 0x30 to 0x3C. Bytes beyond the count keep their previous values.
- R7: Writing 1 to control bit 0 while idle starts a transaction. Bit 0 reads 1 from the following cycle until the transaction completes, and then reads 0.
- R8: Control bits 9:8 select which chip-select output goes low during a transaction. No more than one chip select is ever low.
- R9: When control bit 16 is 1 at completion, the chip select returns high. When it is 0, the chip select stays low after completion, and a later write of 1 to bit 16 while idle raises it.
- R10: Completion sets ready bit 24. Writing 1 to bit 24 clears it. The interrupt output is high exactly while both the ready bit and enable bit 25 are set.
- R11: While a transaction is busy, register writes are ignored, except a write of 1 that clears the ready bit. This includes any start request.
- R12: During the dummy and read phases no data line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | NUM_CS | Active-low chip selects |
| spi_io_o | output | 4 | Data line output values |
| spi_io_oe_o | output | 4 | Data line output enables |
| spi_io_i | input | 4 | Data line input values |
| irq_o | output | 1 | Ready interrupt |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a running transfer. The bench reaches it by starting a sixteen-byte single-line write, which takes hundreds of cycles. During that write it rewrites the opcode, configuration and address registers and issues a second start request. Afterwards it confirms that the recorded line trace and the register readback both match the original settings. Read data is produced by a lane model that advances on every rising serial clock edge, so each received bit arrives exactly in the beat where the engine samples it.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int MAX_DATA = 16;
  localparam int DCNT_W   = $clog2(MAX_DATA + 1);
  localparam int WORDS    = MAX_DATA / 4;

  localparam logic [7:0] OFS_CFG  = 8'h08;
  localparam logic [7:0] OFS_CTL  = 8'h0C;
  localparam logic [7:0] OFS_OPC  = 8'h10;
  localparam logic [7:0] OFS_ADR  = 8'h14;
  localparam logic [7:0] OFS_WD0  = 8'h20;
  localparam logic [7:0] OFS_RD0  = 8'h30;
  localparam logic [31:0] CFG_MASK = 32'h1FFF_3FFF;

  typedef enum logic [2:0] {
    PH_NONE = 3'd0, PH_CMD = 3'd1, PH_ADDR = 3'd2,
    PH_DUM  = 3'd3, PH_WR  = 3'd4, PH_RD   = 3'd5
  } phase_e;

  typedef struct packed {
    logic [1:0]        cmd_bpc;
    logic [1:0]        addr_bpc;
    logic [1:0]        wr_bpc;
    logic [1:0]        dum_bpc;
    logic [1:0]        rd_bpc;
    logic              cmd_en;
    logic [2:0]        addr_n;
    logic [2:0]        dum_n;
    logic [DCNT_W-1:0] wr_n;
    logic [DCNT_W-1:0] rd_n;
  } xfer_cfg_t;

  function automatic logic [1:0] clamp_bpc(logic [1:0] v);
    return (v == 2'd3) ? 2'd2 : v;
  endfunction

  function automatic logic [DCNT_W-1:0] clamp_cnt(logic [4:0] v);
    return (v > 5'(MAX_DATA)) ? DCNT_W'(MAX_DATA) : DCNT_W'(v);
  endfunction

  function automatic xfer_cfg_t decode_cfg(logic [31:0] r);
    xfer_cfg_t c;
    c.cmd_bpc  = clamp_bpc(r[1:0]);
    c.addr_bpc = clamp_bpc(r[3:2]);
    c.wr_bpc   = clamp_bpc(r[5:4]);
    c.dum_bpc  = clamp_bpc(r[7:6]);
    c.rd_bpc   = clamp_bpc(r[9:8]);
    c.cmd_en   = r[10];
    c.addr_n   = (r[13:11] > 3'd4) ? 3'd4 : r[13:11];
    c.wr_n     = clamp_cnt(r[20:16]);
    c.dum_n    = r[23:21];
    c.rd_n     = clamp_cnt(r[28:24]);
    return c;
  endfunction

  function automatic logic [DCNT_W-1:0] phase_len(xfer_cfg_t c, phase_e p);
    case (p)
      PH_CMD:  return DCNT_W'(c.cmd_en);
      PH_ADDR: return DCNT_W'(c.addr_n);
      PH_DUM:  return DCNT_W'(c.dum_n);
      PH_WR:   return c.wr_n;
      PH_RD:   return c.rd_n;
      default: return '0;
    endcase
  endfunction

  function automatic logic [1:0] phase_bpc(xfer_cfg_t c, phase_e p);
    case (p)
      PH_CMD:  return c.cmd_bpc;
      PH_ADDR: return c.addr_bpc;
      PH_DUM:  return c.dum_bpc;
      PH_WR:   return c.wr_bpc;
      PH_RD:   return c.rd_bpc;
      default: return 2'd0;
    endcase
  endfunction

  // first non-empty phase strictly after cur (PH_NONE scans from the start)
  function automatic phase_e next_phase(xfer_cfg_t c, phase_e cur);
    phase_e res = PH_NONE;
    for (int p = 5; p >= 1; p--) begin
      if (p > int'(cur) && phase_len(c, phase_e'(p[2:0])) != '0)
        res = phase_e'(p[2:0]);
    end
    return res;
  endfunction

  function automatic logic [2:0] beats_m1(logic [1:0] bpc);
    case (bpc)
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/spi_xfer_lane.sv
module spi_xfer_lane (
  input  logic [7:0] tx_sr_i,
  input  logic [1:0] bpc_i,
  input  logic       drive_i,
  input  logic [7:0] rx_sr_i,
  input  logic [3:0] io_i,
  output logic [3:0] io_o,
  output logic [3:0] io_oe_o,
  output logic [7:0] rx_nxt_o
);
  logic [3:0] out_v, oe_v;

  always_comb begin
    case (bpc_i)
      2'd0: begin
        out_v    = {3'b000, tx_sr_i[7]};
        oe_v     = 4'b0001;
        rx_nxt_o = {rx_sr_i[6:0], io_i[1]};
      end
      2'd1: begin
        out_v    = {2'b00, tx_sr_i[7:6]};
        oe_v     = 4'b0011;
        rx_nxt_o = {rx_sr_i[5:0], io_i[1:0]};
      end
      default: begin
        out_v    = tx_sr_i[7:4];
        oe_v     = 4'b1111;
        rx_nxt_o = {rx_sr_i[3:0], io_i};
      end
    endcase
  end

  assign io_o    = drive_i ? out_v : 4'b0000;
  assign io_oe_o = drive_i ? oe_v  : 4'b0000;
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_xfer_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  rel_i,
  input  logic                  rel_set_i,
  input  xfer_cfg_t             cfg_i,
  input  logic [7:0]            cmd_i,
  input  logic [31:0]           addr_i,
  input  logic [8*MAX_DATA-1:0] wbytes_i,
  input  logic [3:0]            io_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  rx_we_o,
  output logic [3:0]            rx_idx_o,
  output logic [7:0]            rx_byte_o,
  output logic                  sclk_o,
  output logic [3:0]            io_o,
  output logic [3:0]            io_oe_o,
  output logic                  cs_act_o
);
  logic              busy_q, sclk_q, cs_act_q;
  phase_e            phase_q, ld_phase;
  logic [DCNT_W-1:0] idx_q, ld_idx, cur_len;
  logic [2:0]        beat_q, ld_beat;
  logic [7:0]        sr_q, rx_q, ld_byte, rx_nxt, sr_shift;
  logic [1:0]        cur_bpc;
  logic [5:0]        addr_sh;
  logic [31:0]       addr_shifted;
  logic              drive;

  assign cur_len = phase_len(cfg_i, phase_q);
  assign cur_bpc = phase_bpc(cfg_i, phase_q);

  always_comb begin
    if (!busy_q) begin
      ld_phase = next_phase(cfg_i, PH_NONE);
      ld_idx   = '0;
    end else if ((idx_q + DCNT_W'(1)) < cur_len) begin
      ld_phase = phase_q;
      ld_idx   = idx_q + DCNT_W'(1);
    end else begin
      ld_phase = next_phase(cfg_i, phase_q);
      ld_idx   = '0;
    end
  end

  assign addr_sh      = {cfg_i.addr_n - 3'd1 - ld_idx[2:0], 3'b000};
  assign addr_shifted = addr_i >> addr_sh;

  always_comb begin
    case (ld_phase)
      PH_CMD:  ld_byte = cmd_i;
      PH_ADDR: ld_byte = addr_shifted[7:0];
      PH_WR:   ld_byte = wbytes_i[{ld_idx[3:0], 3'b000} +: 8];
      default: ld_byte = 8'h00;
    endcase
    ld_beat = beats_m1(phase_bpc(cfg_i, ld_phase));
    case (cur_bpc)
      2'd0:    sr_shift = {sr_q[6:0], 1'b0};
      2'd1:    sr_shift = {sr_q[5:0], 2'b00};
      default: sr_shift = {sr_q[3:0], 4'b0000};
    endcase
  end

  assign drive = busy_q && (phase_q == PH_CMD || phase_q == PH_ADDR || phase_q == PH_WR);

  spi_xfer_lane u_lane (
    .tx_sr_i  (sr_q),
    .bpc_i    (cur_bpc),
    .drive_i  (drive),
    .rx_sr_i  (rx_q),
    .io_i     (io_i),
    .io_o     (io_o),
    .io_oe_o  (io_oe_o),
    .rx_nxt_o (rx_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      cs_act_q <= 1'b0;
      phase_q  <= PH_NONE;
      idx_q    <= '0;
      beat_q   <= '0;
      sr_q     <= '0;
      rx_q     <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      cs_act_q <= 1'b1;
      sclk_q   <= 1'b0;
      phase_q  <= ld_phase;
      idx_q    <= ld_idx;
      beat_q   <= ld_beat;
      sr_q     <= ld_byte;
    end else if (busy_q) begin
      if (phase_q == PH_NONE) begin
        busy_q <= 1'b0;
        if (rel_i) cs_act_q <= 1'b0;
      end else if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= rx_nxt;
      end else begin
        sclk_q <= 1'b0;
        if (beat_q != 3'd0) begin
          beat_q <= beat_q - 3'd1;
          sr_q   <= sr_shift;
        end else begin
          phase_q <= ld_phase;
          idx_q   <= ld_idx;
          beat_q  <= ld_beat;
          sr_q    <= ld_byte;
        end
      end
    end else if (rel_set_i) begin
      cs_act_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && (phase_q == PH_NONE);
  assign rx_we_o   = busy_q && sclk_q && (beat_q == 3'd0) && (phase_q == PH_RD);
  assign rx_idx_o  = idx_q[3:0];
  assign rx_byte_o = rx_q;
  assign sclk_o    = sclk_q;
  assign cs_act_o  = cs_act_q;

  // R2: clock pulses only inside a transaction
  a_r2_sclk_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> busy_q);
  // R12: lanes released in dummy and read phases
  a_r12_lanes_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (phase_q == PH_DUM || phase_q == PH_RD)) |-> (io_oe_o == 4'b0000));
  // R7: completion ends busy on the next cycle
  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/spi_xfer_regs.sv
module spi_xfer_regs
  import spi_xfer_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic                  busy_i,
  input  logic                  done_i,
  input  logic                  rx_we_i,
  input  logic [3:0]            rx_idx_i,
  input  logic [7:0]            rx_byte_i,
  output xfer_cfg_t             cfg_o,
  output logic [7:0]            cmd_o,
  output logic [31:0]           addr_o,
  output logic [8*MAX_DATA-1:0] wbytes_o,
  output logic [1:0]            sel_o,
  output logic                  rel_o,
  output logic                  start_o,
  output logic                  rel_set_o,
  output logic                  irq_o
);
  logic [31:0]           cfg_q, addr_q;
  logic [7:0]            cmd_q;
  logic [8*MAX_DATA-1:0] wbytes_q, rbytes_q;
  logic [1:0]            sel_q;
  logic                  rel_q, ie_q, rdy_q;
  logic                  wr_ok, ctl_wr;

  assign wr_ok     = we_i && !busy_i;
  assign ctl_wr    = wr_ok && (addr_i == OFS_CTL);
  assign start_o   = ctl_wr && wdata_i[0];
  assign rel_set_o = ctl_wr && wdata_i[16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      addr_q   <= '0;
      cmd_q    <= '0;
      wbytes_q <= '0;
      rbytes_q <= '0;
      sel_q    <= '0;
      rel_q    <= 1'b1;
      ie_q     <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      if (wr_ok && addr_i == OFS_CFG) cfg_q  <= wdata_i & CFG_MASK;
      if (wr_ok && addr_i == OFS_OPC) cmd_q  <= wdata_i[7:0];
      if (wr_ok && addr_i == OFS_ADR) addr_q <= wdata_i;
      for (int w = 0; w < WORDS; w++) begin
        if (wr_ok && addr_i == OFS_WD0 + 8'(4 * w)) wbytes_q[32*w +: 32] <= wdata_i;
      end
      if (ctl_wr) begin
        sel_q <= wdata_i[9:8];
        rel_q <= wdata_i[16];
        ie_q  <= wdata_i[25];
      end
      if (done_i) rdy_q <= 1'b1;
      else if (we_i && addr_i == OFS_CTL && wdata_i[24]) rdy_q <= 1'b0;
      if (rx_we_i) rbytes_q[{rx_idx_i, 3'b000} +: 8] <= rx_byte_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CFG: rdata_o = cfg_q;
      OFS_CTL: rdata_o = {6'b0, ie_q, rdy_q, 7'b0, rel_q, 6'b0, sel_q, 7'b0, busy_i};
      OFS_OPC: rdata_o = {24'b0, cmd_q};
      OFS_ADR: rdata_o = addr_q;
      default: ;
    endcase
    for (int w = 0; w < WORDS; w++) begin
      if (addr_i == OFS_WD0 + 8'(4 * w)) rdata_o = wbytes_q[32*w +: 32];
      if (addr_i == OFS_RD0 + 8'(4 * w)) rdata_o = rbytes_q[32*w +: 32];
    end
  end

  assign cfg_o    = decode_cfg(cfg_q);
  assign cmd_o    = cmd_q;
  assign addr_o   = addr_q;
  assign wbytes_o = wbytes_q;
  assign sel_o    = sel_q;
  assign rel_o    = rel_q;
  assign irq_o    = rdy_q && ie_q;

  // R10: ready only rises as a transaction ends
  a_r10_rdy_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> $fell(busy_i));
  // R11: setup frozen while busy
  a_r11_setup_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(cfg_q) && $stable(cmd_q) && $stable(addr_q)));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              spi_sclk_o,
  output logic [NUM_CS-1:0] spi_cs_no,
  output logic [3:0]        spi_io_o,
  output logic [3:0]        spi_io_oe_o,
  input  logic [3:0]        spi_io_i,
  output logic              irq_o
);
  xfer_cfg_t             cfg;
  logic [7:0]            cmd, rx_byte;
  logic [31:0]           addr;
  logic [8*MAX_DATA-1:0] wbytes;
  logic [1:0]            sel;
  logic [3:0]            rx_idx;
  logic                  rel, start, rel_set, busy, done, rx_we, cs_act;

  spi_xfer_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .done_i    (done),
    .rx_we_i   (rx_we),
    .rx_idx_i  (rx_idx),
    .rx_byte_i (rx_byte),
    .cfg_o     (cfg),
    .cmd_o     (cmd),
    .addr_o    (addr),
    .wbytes_o  (wbytes),
    .sel_o     (sel),
    .rel_o     (rel),
    .start_o   (start),
    .rel_set_o (rel_set),
    .irq_o     (irq_o)
  );

  spi_xfer_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rel_i     (rel),
    .rel_set_i (rel_set),
    .cfg_i     (cfg),
    .cmd_i     (cmd),
    .addr_i    (addr),
    .wbytes_i  (wbytes),
    .io_i      (spi_io_i),
    .busy_o    (busy),
    .done_o    (done),
    .rx_we_o   (rx_we),
    .rx_idx_o  (rx_idx),
    .rx_byte_o (rx_byte),
    .sclk_o    (spi_sclk_o),
    .io_o      (spi_io_o),
    .io_oe_o   (spi_io_oe_o),
    .cs_act_o  (cs_act)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_no[i] = !(cs_act && (sel == 2'(i)));
  end

  // R8: at most one select low
  a_r8_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~spi_cs_no));
  // R9: select stays low throughout a transaction
  a_r9_cs_during_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(spi_cs_no));
endmodule

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CFG = 8'h08, A_CTL = 8'h0C, A_OPC = 8'h10, A_ADR = 8'h14;
  localparam logic [7:0] A_WD0 = 8'h20, A_RD0 = 8'h30;

  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [7:0]  raddr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        sclk, irq;
  logic [3:0]  cs_n, io_o, io_oe, io_i;

  logic [3:0] rx_pat [4096];
  logic [3:0] tr_val [4096];
  logic [3:0] tr_oe  [4096];
  logic [3:0] exp_val [1024];
  logic [3:0] exp_oe  [1024];
  int n_tr = 0;
  int n_exp, base;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_engine #(.NUM_CS(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .spi_sclk_o(sclk),
    .spi_cs_no(cs_n), .spi_io_o(io_o), .spi_io_oe_o(io_oe),
    .spi_io_i(io_i), .irq_o(irq)
  );

  assign io_i = rx_pat[n_tr[11:0]];

  always @(posedge sclk) begin
    tr_val[n_tr[11:0]] <= io_o;
    tr_oe[n_tr[11:0]]  <= io_oe;
    n_tr <= n_tr + 1;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; raddr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle;
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(A_CTL, v);
      if (!v[0]) return;
    end
    check("R7", "busy timeout", 1, 0);
  endtask

  function automatic logic [31:0] mkcfg(int cb, int ab, int wb, int db, int rb,
                                         int ce, int an, int wn, int dn, int rn);
    logic [31:0] c = 0;
    c[1:0] = 2'(cb); c[3:2] = 2'(ab); c[5:4] = 2'(wb); c[7:6] = 2'(db); c[9:8] = 2'(rb);
    c[10] = 1'(ce); c[13:11] = 3'(an); c[20:16] = 5'(wn); c[23:21] = 3'(dn); c[28:24] = 5'(rn);
    return c;
  endfunction

  task automatic begin_trace;
    @(negedge clk);
    base = n_tr;
    n_exp = 0;
  endtask

  task automatic push_tx(input logic [7:0] b, input int bpc);
    int w = 1 << bpc;
    for (int k = 0; k < 8 / w; k++) begin
      exp_val[n_exp] = 4'((b >> (8 - w * (k + 1))) & ((1 << w) - 1));
      exp_oe[n_exp]  = 4'((1 << w) - 1);
      n_exp++;
    end
  endtask

  task automatic push_quiet(input int bpc);
    for (int k = 0; k < 8 / (1 << bpc); k++) begin
      exp_val[n_exp] = 0; exp_oe[n_exp] = 0; n_exp++;
    end
  endtask

  task automatic push_rx(input logic [7:0] b, input int bpc);
    int w = 1 << bpc;
    logic [3:0] bits;
    for (int k = 0; k < 8 / w; k++) begin
      bits = 4'((b >> (8 - w * (k + 1))) & ((1 << w) - 1));
      rx_pat[12'(base + n_exp)] = (bpc == 0) ? {2'b00, bits[0], 1'b0} : bits;
      exp_val[n_exp] = 0; exp_oe[n_exp] = 0; n_exp++;
    end
  endtask

  task automatic check_trace(input string req);
    int got = n_tr - base;
    int bad = -1;
    check(req, "beat count", 32'(got), 32'(n_exp));
    for (int j = 0; j < n_exp && j < got; j++) begin
      if (bad < 0 && (tr_oe[12'(base + j)] !== exp_oe[j] ||
          (tr_val[12'(base + j)] & exp_oe[j]) !== (exp_val[j] & exp_oe[j])))
        bad = j;
    end
    n_tests++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s beat %0d: actual io=%h oe=%h expected io=%h oe=%h", req, bad,
               tr_val[12'(base + bad)], tr_oe[12'(base + bad)], exp_val[bad], exp_oe[bad]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTL, v);
    check("R1", "control word", v, 32'h0001_0000);
    check("R1", "chip selects", 32'(cs_n), 32'hF);
    check("R1", "sclk/oe/irq", {28'b0, sclk, irq, |io_oe, 1'b0}, 0);
  endtask

  task automatic t_cmd_only;
    logic [31:0] v;
    wr(A_CFG, mkcfg(0,0,0,0,0, 1,0,0,0,0));
    wr(A_OPC, 32'h9F);
    begin_trace;
    push_tx(8'h9F, 0);
    wr(A_CTL, 32'h0001_0201);
    rd(A_CTL, v);
    check("R7", "busy after start", 32'(v[0]), 1);
    check("R8", "select 2 low", 32'(cs_n), 32'hB);
    wait_idle;
    rd(A_CTL, v);
    check("R7", "busy after end", 32'(v[0]), 0);
    check_trace("R2");
    check("R9", "released select", 32'(cs_n), 32'hF);
  endtask

  task automatic t_addr_read;
    logic [31:0] v;
    wr(A_CFG, mkcfg(0,0,0,0,0, 1,3,0,1,5));
    wr(A_OPC, 32'h03);
    wr(A_ADR, 32'hAABB_CCDD);
    begin_trace;
    push_tx(8'h03, 0); push_tx(8'hBB, 0); push_tx(8'hCC, 0); push_tx(8'hDD, 0);
    push_quiet(0);
    push_rx(8'hA1, 0); push_rx(8'hB2, 0); push_rx(8'hC3, 0); push_rx(8'hD4, 0); push_rx(8'hE5, 0);
    wr(A_CTL, 32'h0001_0001);
    wait_idle;
    check_trace("R4 R12");
    rd(A_RD0, v);
    check("R6", "read word 0", v, 32'hD4C3_B2A1);
    rd(A_RD0 + 8'h4, v);
    check("R6", "read word 1 low byte", {24'b0, v[7:0]}, 32'hE5);
  endtask

  task automatic t_quad_write;
    logic [7:0] b [16];
    for (int k = 0; k < 16; k++) b[k] = 8'hF0 ^ 8'(k * 7);
    for (int w = 0; w < 4; w++) wr(A_WD0 + 8'(4 * w), {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]});
    wr(A_CFG, mkcfg(0,2,2,0,0, 1,4,16,0,0));
    wr(A_OPC, 32'h38);
    wr(A_ADR, 32'h1234_5678);
    begin_trace;
    push_tx(8'h38, 0);
    push_tx(8'h12, 2); push_tx(8'h34, 2); push_tx(8'h56, 2); push_tx(8'h78, 2);
    for (int k = 0; k < 16; k++) push_tx(b[k], 2);
    wr(A_CTL, 32'h0001_0101);
    wait_idle;
    check_trace("R3 R5");
  endtask

  task automatic t_dual_read;
    logic [31:0] v;
    wr(A_CFG, mkcfg(1,0,0,0,1, 1,0,0,0,2));
    wr(A_OPC, 32'hBB);
    begin_trace;
    push_tx(8'hBB, 1);
    push_rx(8'h5A, 1); push_rx(8'hC3, 1);
    wr(A_CTL, 32'h0001_0001);
    wait_idle;
    check_trace("R3");
    rd(A_RD0, v);
    check("R6", "dual read keeps upper bytes", v, 32'hD4C3_C35A);
  endtask

  task automatic t_hold;
    wr(A_CFG, mkcfg(0,0,0,0,0, 1,0,0,0,0));
    wr(A_OPC, 32'h06);
    wr(A_CTL, 32'h0000_0001);
    wait_idle;
    check("R9", "held after first", 32'(cs_n), 32'hE);
    begin_trace;
    push_tx(8'h06, 0);
    wr(A_CTL, 32'h0000_0001);
    wait_idle;
    check_trace("R9");
    check("R9", "held after second", 32'(cs_n), 32'hE);
    wr(A_CTL, 32'h0001_0000);
    check("R9", "release raises select", 32'(cs_n), 32'hF);
  endtask

  task automatic t_ready_irq;
    logic [31:0] v;
    rd(A_CTL, v);
    check("R10", "ready set", 32'(v[24]), 1);
    check("R10", "irq masked", 32'(irq), 0);
    wr(A_CTL, 32'h0301_0000);
    rd(A_CTL, v);
    check("R10", "ready cleared", 32'(v[24]), 0);
    check("R10", "irq low after clear", 32'(irq), 0);
    wr(A_CTL, 32'h0201_0001);
    wait_idle;
    check("R10", "irq on completion", 32'(irq), 1);
    wr(A_CTL, 32'h0301_0000);
    check("R10", "irq cleared by W1C", 32'(irq), 0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v, cfgv;
    cfgv = mkcfg(0,0,0,0,0, 1,0,16,0,0);
    wr(A_CFG, cfgv);
    wr(A_OPC, 32'h02);
    wr(A_ADR, 32'h0000_0042);
    begin_trace;
    push_tx(8'h02, 0);
    for (int k = 0; k < 16; k++) push_tx(8'hF0 ^ 8'(k * 7), 0);
    wr(A_CTL, 32'h0001_0001);
    wr(A_OPC, 32'h00);
    wr(A_CFG, 32'h0);
    wr(A_ADR, 32'hFFFF_FFFF);
    wr(A_CTL, 32'h0001_0301);
    check("R11", "select unchanged mid-run", 32'(cs_n), 32'hE);
    wait_idle;
    check_trace("R11");
    rd(A_OPC, v);  check("R11", "opcode kept", v, 32'h02);
    rd(A_CFG, v);  check("R11", "config kept", v, cfgv);
    rd(A_ADR, v);  check("R11", "address kept", v, 32'h42);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr(A_CTL, 32'h0101_0000);
    wr(A_CFG, 32'h0);
    begin_trace;
    wr(A_CTL, 32'h0001_0001);
    wait_idle;
    check_trace("R2");
    rd(A_CTL, v);
    check("R10", "ready after empty run", 32'(v[24]), 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) rx_pat[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cmd_only;
    t_addr_read;
    t_quad_write;
    t_dual_read;
    t_hold;
    t_ready_irq;
    t_busy_ignore;
    t_zero;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule